// File: doc/BRIEF.md
# Statically Scheduled Fixed-Point Arithmetic Sequencer

This block evaluates short fixed-point expressions, such as a small FIR-style filter with persistent state, by running a straight-line program of instructions. After a start pulse it issues one instruction per cycle from a local instruction memory, with no branches. The operations are no-op, add, subtract, multiply, arithmetic right shift, copy, input and output. Operands are read from a register file. The lowest register addresses hold constants and state variables that keep their values from one run to the next. Working registers sit above them.

Each kind of operation has its own fixed latency. Its result, together with its destination address, travels down a pipeline and is written back when it reaches the end. The block has no interlocks and no hazard checks, and the register file has a single write port. An offline scheduler is therefore responsible for ordering operands correctly, for making sure no two results complete in the same cycle, and for padding the program with no-ops until the last result has landed. A load port fills the instruction memory, the register file and the index of the final program word while the block is idle.

Top module: `fxp_seq_core`

## Requirements
- R1: After reset, done_o, result_stb_o and result_o are all 0, and every register is 0.
- R2: A start_i pulse while idle clears done_o and issues words 0 up to the final index, one per cycle. done_o rises on the clock edge after the final word issues and then stays high until the next start. A start_i pulse during a run has no effect.
- R3: Add (opcode 1) and subtract (opcode 2, src_a minus src_b) wrap at 32 bits. A result is readable by an instruction issued two cycles after it.
- R4: Multiply (opcode 3) keeps the low 32 bits of the product. The result is readable 1+MUL_STAGES cycles after issue, which is 3 with the defaults.
- R5: Shift (opcode 4) moves src_a arithmetically right by the 5-bit immediate. The result is readable two cycles after issue.
- R6: Copy (opcode 5) moves src_a to dst. The result is readable on the next cycle.
- R7: Input (opcode 6) writes sample_i to dst, readable on the next cycle, provided sample_valid_i is high in the issue cycle. If sample_valid_i is low, dst is left unchanged.
- R8: Output (opcode 7) places src_a on result_o and raises result_stb_o for exactly one cycle, on the cycle after issue. result_o holds that value until the next output.
- R9: Load writes are accepted only while idle. load_sel_i selects the target: 0 is an instruction word, 1 is a register, and 2 is the final index. A load attempted during a run changes nothing.
- R10: An instruction issued before its source's latency has elapsed reads the old register value.
- R11: At most one pipeline completes in any cycle.
- R12: Instruction word fields are: opcode [19:17], dst [16:13], src_a [12:9], src_b [8:5], immediate [4:0]. Opcode 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| done_o | output | 1 | High after a run completes, until the next start |
| sample_i | input | 32 | Sample value consumed by the input instruction |
| sample_valid_i | input | 1 | Qualifies sample_i |
| result_o | output | 32 | Value from the last output instruction |
| result_stb_o | output | 1 | One-cycle strobe on each new result |
| load_we_i | input | 1 | Load write enable |
| load_sel_i | input | 2 | Load target: 0 instruction, 1 register, 2 final index |
| load_addr_i | input | 5 | Load address |
| load_data_i | input | 32 | Load data; an instruction uses the low 20 bits |

## Verification
The hardest case to reach is the timing boundary of each latency class: a read issued one cycle too early must return the stale value, and a read issued exactly on time must return the new one. A hand-scheduled program places output instructions on both sides of the write-back cycle of an add, a multiply and a copy. A second run of that program pulses start and a register load in the middle of execution, which shows that neither has any effect. A long sweep then pushes edge-case and pseudo-random samples through a three-tap filter program, including cycles where the sample is not valid. Each filter output and its shifted copy is compared with an arithmetic model.

// File: rtl/fxp_seq_pkg.sv
`timescale 1ns/1ps
package fxp_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MUL = 3'd3,
    OP_SHR = 3'd4, OP_CPY = 3'd5, OP_INP = 3'd6, OP_OUT = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    LD_IMEM = 2'd0, LD_REG = 2'd1, LD_LAST = 2'd2, LD_NONE = 2'd3
  } ld_sel_e;

  localparam int LANES    = 3;
  localparam int LANE_MOV = 0;  // copy / input
  localparam int LANE_ALU = 1;  // add / sub / shift
  localparam int LANE_MUL = 2;

  // register stages between issue and write-back, per lane
  function automatic int lane_depth(int lane, int mul_stages);
    case (lane)
      LANE_MOV: return 0;
      LANE_ALU: return 1;
      default:  return mul_stages;
    endcase
  endfunction
endpackage

// File: rtl/fxp_seq_delay.sv
`timescale 1ns/1ps
module fxp_seq_delay #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] pl_i,
  output logic         vld_o,
  output logic [W-1:0] pl_o
);
  if (DEPTH == 0) begin : g_pass
    assign vld_o = vld_i;
    assign pl_o  = pl_i;
  end else begin : g_pipe
    logic         vld_q [DEPTH];
    logic [W-1:0] pl_q  [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) begin
          vld_q[i] <= 1'b0;
          pl_q[i]  <= '0;
        end
      end else begin
        vld_q[0] <= vld_i;
        pl_q[0]  <= pl_i;
        for (int i = 1; i < DEPTH; i++) begin
          vld_q[i] <= vld_q[i-1];
          pl_q[i]  <= pl_q[i-1];
        end
      end
    end
    assign vld_o = vld_q[DEPTH-1];
    assign pl_o  = pl_q[DEPTH-1];
  end
endmodule

// File: rtl/fxp_seq_ctrl.sv
`timescale 1ns/1ps
module fxp_seq_ctrl #(
  parameter int PC_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PC_W-1:0] last_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [PC_W-1:0] pc_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pc_o   <= '0;
      done_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          pc_o   <= '0;
          done_o <= 1'b0;
        end
        default: begin
          if (pc_o == last_i) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else begin
            pc_o <= pc_o + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q == ST_RUN);
endmodule

// File: rtl/fxp_seq_regfile.sv
`timescale 1ns/1ps
module fxp_seq_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  input  logic [ADDR_W-1:0] rb_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  localparam int NREG = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign a_o = mem_q[ra_i];
  assign b_o = mem_q[rb_i];
endmodule

// File: rtl/fxp_seq_exec.sv
`timescale 1ns/1ps
module fxp_seq_exec
  import fxp_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SH_W       = 5,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  output logic              wb_vld_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [LANES-1:0]  lane_vld_o
);
  localparam int PL_W = ADDR_W + DATA_W;

  logic [LANES-1:0] in_vld;
  logic [PL_W-1:0]  in_pl  [LANES];
  logic [PL_W-1:0]  out_pl [LANES];
  logic [DATA_W-1:0] alu_res, mov_res, mul_res;

  assign mul_res = a_i * b_i;  // low DATA_W bits

  always_comb begin
    case (op_i)
      OP_ADD:  alu_res = a_i + b_i;
      OP_SUB:  alu_res = a_i - b_i;
      default: alu_res = $signed(a_i) >>> shamt_i;
    endcase
    mov_res = (op_i == OP_INP) ? sample_i : a_i;

    in_vld           = '0;
    in_vld[LANE_MOV] = (op_i == OP_CPY) || (op_i == OP_INP && sample_valid_i);
    in_vld[LANE_ALU] = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_SHR);
    in_vld[LANE_MUL] = (op_i == OP_MUL);
    in_pl[LANE_MOV]  = {dst_i, mov_res};
    in_pl[LANE_ALU]  = {dst_i, alu_res};
    in_pl[LANE_MUL]  = {dst_i, mul_res};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fxp_seq_delay #(
      .DEPTH(lane_depth(g, MUL_STAGES)),
      .W    (PL_W)
    ) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (in_vld[g]),
      .pl_i  (in_pl[g]),
      .vld_o (lane_vld_o[g]),
      .pl_o  (out_pl[g])
    );
  end

  // schedule guarantees one completion per cycle; lowest lane wins otherwise
  always_comb begin
    wb_vld_o  = 1'b0;
    wb_addr_o = '0;
    wb_data_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (lane_vld_o[i]) begin
        wb_vld_o               = 1'b1;
        {wb_addr_o, wb_data_o} = out_pl[i];
      end
    end
  end
endmodule

// File: rtl/fxp_seq_core.sv
`timescale 1ns/1ps
module fxp_seq_core
  import fxp_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,   // register file address width, <= PC_W
  parameter int PC_W       = 5,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_stb_o,
  input  logic              load_we_i,
  input  logic [1:0]        load_sel_i,
  input  logic [PC_W-1:0]   load_addr_i,
  input  logic [DATA_W-1:0] load_data_i
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int IW     = 3 + 3 * ADDR_W + SH_W;
  localparam int NWORDS = 1 << PC_W;

  logic              busy;
  logic [PC_W-1:0]   pc, last_q;
  logic [IW-1:0]     imem [NWORDS];
  logic [IW-1:0]     instr;
  op_e               iss_op;
  logic [ADDR_W-1:0] f_dst, f_sa, f_sb;
  logic [SH_W-1:0]   f_imm;
  logic [DATA_W-1:0] rd_a, rd_b;
  logic              wb_vld;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [LANES-1:0]  lane_vld;
  logic              ld_ok, ld_imem, ld_reg, ld_last;
  logic              rf_we;
  logic [ADDR_W-1:0] rf_wa;
  logic [DATA_W-1:0] rf_wd;

  assign ld_ok   = load_we_i && !busy;
  assign ld_imem = ld_ok && (load_sel_i == LD_IMEM);
  assign ld_reg  = ld_ok && (load_sel_i == LD_REG);
  assign ld_last = ld_ok && (load_sel_i == LD_LAST);

  fxp_seq_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .last_i (last_q),
    .busy_o (busy),
    .done_o (done_o),
    .pc_o   (pc)
  );

  always_ff @(posedge clk_i) begin
    if (ld_imem) imem[load_addr_i] <= load_data_i[IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= '0;
    else if (ld_last) last_q <= load_data_i[PC_W-1:0];
  end

  assign instr  = imem[pc];
  assign iss_op = busy ? op_e'(instr[IW-1 -: 3]) : OP_NOP;
  assign f_dst  = instr[IW-4 -: ADDR_W];
  assign f_sa   = instr[IW-4-ADDR_W -: ADDR_W];
  assign f_sb   = instr[IW-4-2*ADDR_W -: ADDR_W];
  assign f_imm  = instr[SH_W-1:0];

  // single write port: loads only while idle, write-back otherwise
  assign rf_we = ld_reg || wb_vld;
  assign rf_wa = ld_reg ? load_addr_i[ADDR_W-1:0] : wb_addr;
  assign rf_wd = ld_reg ? load_data_i : wb_data;

  fxp_seq_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (rf_we),
    .wa_i  (rf_wa),
    .wd_i  (rf_wd),
    .ra_i  (f_sa),
    .rb_i  (f_sb),
    .a_o   (rd_a),
    .b_o   (rd_b)
  );

  fxp_seq_exec #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SH_W      (SH_W),
    .MUL_STAGES(MUL_STAGES)
  ) u_exec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (iss_op),
    .dst_i         (f_dst),
    .a_i           (rd_a),
    .b_i           (rd_b),
    .shamt_i       (f_imm),
    .sample_i      (sample_i),
    .sample_valid_i(sample_valid_i),
    .wb_vld_o      (wb_vld),
    .wb_addr_o     (wb_addr),
    .wb_data_o     (wb_data),
    .lane_vld_o    (lane_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o     <= '0;
      result_stb_o <= 1'b0;
    end else begin
      result_stb_o <= (iss_op == OP_OUT);
      if (iss_op == OP_OUT) result_o <= rd_a;
    end
  end
endmodule

// File: rtl/fxp_seq_chk.sv
`timescale 1ns/1ps
module fxp_seq_chk
  import fxp_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input op_e              iss_op_i,
  input logic             stb_i,
  input logic [LANES-1:0] lane_vld_i
);
  assert_one_wb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_vld_i));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && !done_i));

  assert_end_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  assert_done_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> done_i);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_out_stb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_op_i == OP_OUT) |=> stb_i);

  assert_no_stray_stb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_op_i != OP_OUT) |=> !stb_i);

  assert_alu_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_op_i == OP_ADD || iss_op_i == OP_SUB || iss_op_i == OP_SHR)
      |=> lane_vld_i[LANE_ALU]);

  assert_cpy_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_op_i == OP_CPY) |-> lane_vld_i[LANE_MOV]);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (iss_op_i == OP_NOP));
endmodule

bind fxp_seq_core fxp_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy),
  .done_i    (done_o),
  .iss_op_i  (iss_op),
  .stb_i     (result_stb_o),
  .lane_vld_i(lane_vld)
);

// File: tb/tb_fxp_seq_core.sv
`timescale 1ns/1ps
module tb_fxp_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        done;
  logic [31:0] sample = '0;
  logic        sample_vld = 1'b0;
  logic [31:0] result;
  logic        stb;
  logic        ld_we = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [4:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;

  int nvec = 0;
  int nerr = 0;
  int outs [16];
  int n_out;
  int cycles;

  always #4 clk = ~clk;

  fxp_seq_core dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .sample_i(sample), .sample_valid_i(sample_vld),
    .result_o(result), .result_stb_o(stb),
    .load_we_i(ld_we), .load_sel_i(ld_sel), .load_addr_i(ld_addr),
    .load_data_i(ld_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int dst, input int sa,
                                      input int sb, input int imm);
    return {12'b0, op[2:0], dst[3:0], sa[3:0], sb[3:0], imm[4:0]};
  endfunction

  task automatic ld(input int sel, input int addr, input logic [31:0] data);
    ld_we = 1'b1; ld_sel = sel[1:0]; ld_addr = addr[4:0]; ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // poke_cnt > 0: load r0=1000 at that count, pulse start one count later
  task automatic run(input int poke_cnt);
    n_out = 0;
    cycles = 0;
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      ld_we = 1'b0;
      cycles++;
      if (cycles == 1) chk("R2 done cleared by start", int'(done), 0);
      if (stb && n_out < 16) begin
        outs[n_out] = int'(result);
        n_out++;
      end
      if (done) break;
      if (poke_cnt > 0 && cycles == poke_cnt) begin
        ld_we = 1'b1; ld_sel = 2'd1; ld_addr = 5'd0; ld_data = 32'd1000;
      end
      if (poke_cnt > 0 && cycles == poke_cnt + 1) start = 1'b1;
      if (cycles > 64) begin
        chk("R2 run timeout", cycles, 0);
        break;
      end
    end
  endtask

  int fa, fb, fc, fy, x;
  logic v;
  logic [31:0] lf;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(done), 0);
    chk("R1 stb", int'(stb), 0);
    chk("R1 result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: register zero after reset, read via copy-free output
    ld(0, 0, enc(7, 0, 9, 0, 0));
    ld(2, 0, 32'd0);
    run(0);
    chk("R1 reg zero", outs[0], 0);

    // timing program: boundaries of add, mul, copy
    ld(1, 0, 32'd5); ld(1, 1, 32'd7); ld(1, 6, 32'd99);
    ld(1, 7, -32'sd3); ld(1, 8, 32'd0);
    ld(0, 0, enc(1, 6, 0, 1, 0));
    ld(0, 1, enc(7, 0, 6, 0, 0));
    ld(0, 2, enc(7, 0, 6, 0, 0));
    ld(0, 3, enc(3, 7, 0, 1, 0));
    ld(0, 4, enc(7, 0, 7, 0, 0));
    ld(0, 5, enc(7, 0, 7, 0, 0));
    ld(0, 6, enc(7, 0, 7, 0, 0));
    ld(0, 7, enc(5, 8, 0, 0, 0));
    ld(0, 8, enc(7, 0, 8, 0, 0));
    ld(2, 0, 32'd8);
    run(0);
    chk("R2 run length", cycles, 10);
    chk("R8 strobe count", n_out, 6);
    chk("R10 add read too early", outs[0], 99);
    chk("R3 add after 2", outs[1], 12);
    chk("R10 mul read at 1", outs[2], -3);
    chk("R10 mul read at 2", outs[3], -3);
    chk("R4 mul after 3", outs[4], 35);
    chk("R6 copy after 1", outs[5], 5);
    repeat (3) @(negedge clk);
    chk("R2 done held", int'(done), 1);
    chk("R8 result held", int'(result), 5);

    // R9 load and R2 start ignored during run
    run(4);
    chk("R2 start ignored length", cycles, 10);
    chk("R8 strobe count 2", n_out, 6);
    chk("R3 rerun add", outs[0], 12);
    chk("R4 rerun mul", outs[2], 35);
    chk("R9 load ignored busy", outs[5], 5);

    // filter program: sub, shift, input, persistent state
    ld(1, 0, 32'd4748); ld(1, 1, 32'd259); ld(1, 2, 32'd155);
    ld(1, 3, 32'd0); ld(1, 4, 32'd0); ld(1, 5, 32'd0);
    ld(0, 0,  enc(5, 5, 4, 0, 0));
    ld(0, 1,  enc(5, 4, 3, 0, 0));
    ld(0, 2,  enc(6, 3, 0, 0, 0));
    ld(0, 3,  enc(3, 6, 0, 3, 0));
    ld(0, 4,  enc(3, 7, 1, 4, 0));
    ld(0, 5,  enc(3, 8, 2, 5, 0));
    ld(0, 6,  enc(0, 0, 0, 0, 0));
    ld(0, 7,  enc(1, 9, 6, 7, 0));
    ld(0, 8,  enc(0, 0, 0, 0, 0));
    ld(0, 9,  enc(2, 10, 9, 8, 0));
    ld(0, 10, enc(0, 0, 0, 0, 0));
    ld(0, 11, enc(4, 11, 10, 0, 3));
    ld(0, 12, enc(7, 0, 10, 0, 0));
    ld(0, 13, enc(7, 0, 11, 0, 0));
    ld(2, 0, 32'd13);
    fa = 0; fb = 0; fc = 0;
    lf = 32'h1234_5678;
    for (int k = 0; k < 160; k++) begin
      case (k)
        0: x = 0;
        1: x = 1;
        2: x = -1;
        3: x = 32'h7fff_ffff;
        4: x = 32'h8000_0000;
        default: begin
          lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
          x = int'(lf);
        end
      endcase
      v = (k % 5 != 4);
      sample = x; sample_vld = v;
      run(0);
      fc = fb; fb = fa;
      if (v) fa = x;
      fy = 4748 * fa + 259 * fb - 155 * fc;
      chk("R7 R4 R3 filter output", outs[0], fy);
      chk("R5 shifted output", outs[1], fy >>> 3);
      if (k < 3) chk("R2 filter length", cycles, 15);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL R2 watchdog expired: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule